// File: doc/BRIEF.md
# PLL Configuration Word Calculator

This block turns two numbers into the setup word for the bit-clock PLL of a serial display link. The numbers are the desired bit rate per lane in kbps and the frequency of the reference clock in kHz. A single-cycle `start_i` pulse launches a run. The block first searches for the pre-divider, then computes a rounded-up feedback multiplier, the output frequency that the pair actually gives, and a two-bit frequency band. These fields are packed into a 16-bit word. The block then decodes that word back into a frequency and derives the divider for the low-power escape clock, which is limited to 10 MHz.

All divisions in a run share one restoring divider that produces one quotient bit per cycle. The search loop takes one cycle per step and compares against a product, so it needs no division. When the run ends, `done_o` pulses for one cycle and every result is valid. A zero reference frequency ends the run at once with `err_o` set.

Top module: `pll_word_calc`

## Requirements
- R1: The pre-divider starts at 1 and is incremented while reference / (divider + 1) is at least 5000 kHz, and it never exceeds 31. It appears in word bits 12:8.
- R2: The multiplier equals ceil(rate × divider / reference). Its low 8 bits appear in word bits 7:0.
- R3: `ach_khz_o` equals floor(reference × multiplier / divider).
- R4: Word bits 15:14 hold the band code, taken from the achieved frequency: 3 from 501000 up, 2 from 251000 up, 1 from 126000 up, and 0 below that.
- R5: The word is the low 16 bits of (band << 14) OR (divider << 8) OR multiplier, so multiplier bits above bit 7 are ORed into the upper fields.
- R6: `dec_khz_o` equals floor(reference × m / d). Here m is word bits 7:0 and d is word bits 12:8, and a zero field counts as 1.
- R7: `lp_div_o` equals ceil(`dec_khz_o` / 80000).
- R8: `done_o` is high for exactly one cycle per run, and `busy_o` is high while a run is in progress. A `start_i` pulse during a run has no effect on that run's results.
- R9: A start with reference 0 gives `done_o` together with `err_o` = 1, and the word, frequencies and LP divider all read 0. A good run clears `err_o`.
- R10: After reset, `done_o`, `busy_o`, `err_o`, the word and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launches a run when the block is idle |
| rate_kbps_i | input | 32 | Desired bit rate per lane, in kbps |
| ref_khz_i | input | 32 | Reference frequency, in kHz |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse: the results are valid |
| err_o | output | 1 | The last run had a zero reference |
| word_o | output | 16 | Packed PLL configuration word |
| ach_khz_o | output | 64 | Achieved output frequency |
| dec_khz_o | output | 64 | Frequency decoded back from the word |
| lp_div_o | output | 64 | Divider for the low-power clock |

## Verification
The stimulus table covers several kinds of case. Some references stop the divider search at 1, some stop it part way, and one pushes it into the clamp at 31. Each band threshold is hit exactly and just missed. Some rate and reference pairs divide evenly and others must round the multiplier up or truncate the achieved frequency, which separates ceiling from floor errors. One pair gives a multiplier of 256, whose bit 8 spills into the divider field and whose low byte is zero. That case separates the achieved frequency from the decoded one and exercises the zero-as-one rule. Directed runs cover the zero reference and a start pulse issued while a run is in progress.

// File: rtl/pll_calc_pkg.sv
package pll_calc_pkg;
    localparam int WORD_W      = 16;
    localparam int MUL_FIELD_W = 8;
    localparam int DIV_FIELD_W = 5;
    localparam int DIV_LSB     = 8;
    localparam int BAND_LSB    = 14;

    localparam longint BAND1_KHZ = 126000;
    localparam longint BAND2_KHZ = 251000;
    localparam longint BAND3_KHZ = 501000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEARCH,
        ST_MUL,
        ST_ACH,
        ST_DEC,
        ST_LP
    } calc_state_e;
endpackage

// File: rtl/pll_seq_div.sv
module pll_seq_div #(
    parameter int P = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [P-1:0] dividend_i,
    input  logic [P-1:0] divisor_i,
    output logic         done_o,
    output logic [P-1:0] quot_o
);
    localparam int CW = $clog2(P + 1);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] cnt;
        logic [P-1:0]  rem;
        logic [P-1:0]  quo;
        logic [P-1:0]  dsr;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [P:0] shifted;
    logic [P:0] diff;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        shifted   = {st_q.rem, st_q.quo[P-1]};
        diff      = shifted - {1'b0, st_q.dsr};
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy = 1'b1;
                st_d.cnt  = CW'(P);
                st_d.rem  = '0;
                st_d.quo  = dividend_i;
                st_d.dsr  = divisor_i;
            end
        end else begin
            st_d.quo = {st_q.quo[P-2:0], ~diff[P]};
            st_d.rem = diff[P] ? shifted[P-1:0] : diff[P-1:0];
            st_d.cnt = st_q.cnt - CW'(1);
            if (st_q.cnt == CW'(1)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done_o = st_q.done;
    assign quot_o = st_q.quo;

    // R2
    rem_below_divisor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> (st_q.rem < st_q.dsr));
endmodule

// File: rtl/pll_band_enc.sv
module pll_band_enc
    import pll_calc_pkg::*;
#(
    parameter int P = 64
) (
    input  logic [P-1:0] freq_i,
    output logic [1:0]   band_o
);
    always_comb begin
        if (freq_i >= P'(BAND3_KHZ))      band_o = 2'd3;
        else if (freq_i >= P'(BAND2_KHZ)) band_o = 2'd2;
        else if (freq_i >= P'(BAND1_KHZ)) band_o = 2'd1;
        else                              band_o = 2'd0;
    end
endmodule

// File: rtl/pll_word_calc.sv
module pll_word_calc
    import pll_calc_pkg::*;
#(
    parameter int W            = 32,
    parameter int MIN_POST_KHZ = 5000,
    parameter int MAX_DIV      = 31,
    parameter int LP_KHZ       = 10000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [W-1:0]         rate_kbps_i,
    input  logic [W-1:0]         ref_khz_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic                 err_o,
    output logic [WORD_W-1:0]    word_o,
    output logic [2*W-1:0]       ach_khz_o,
    output logic [2*W-1:0]       dec_khz_o,
    output logic [2*W-1:0]       lp_div_o
);
    localparam int P       = 2 * W;
    localparam int DIV_W   = DIV_FIELD_W;
    localparam int LP_STEP = LP_KHZ * 8;

    typedef struct packed {
        calc_state_e       state;
        logic [W-1:0]      rate;
        logic [W-1:0]      refk;
        logic [DIV_W-1:0]  div;
        logic [WORD_W-1:0] mul_lo;
        logic [WORD_W-1:0] word;
        logic [P-1:0]      ach;
        logic [P-1:0]      dec;
        logic [P-1:0]      lp;
        logic              err;
        logic              done;
        logic              dstart;
        logic [P-1:0]      opa;
        logic [P-1:0]      opb;
    } calc_st_t;

    calc_st_t st_d, st_q;

    logic                   dv_done;
    logic [P-1:0]           dv_quot;
    logic [1:0]             band;
    logic [WORD_W-1:0]      word_w;
    logic [MUL_FIELD_W-1:0] m_dec;
    logic [DIV_FIELD_W-1:0] d_dec;

    pll_seq_div #(.P(P)) i_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (st_q.dstart),
        .dividend_i (st_q.opa),
        .divisor_i  (st_q.opb),
        .done_o     (dv_done),
        .quot_o     (dv_quot)
    );

    pll_band_enc #(.P(P)) i_band (
        .freq_i (dv_quot),
        .band_o (band)
    );

    always_comb begin
        word_w = (WORD_W'(band) << BAND_LSB) | (WORD_W'(st_q.div) << DIV_LSB) | st_q.mul_lo;
        m_dec  = word_w[MUL_FIELD_W-1:0];
        d_dec  = word_w[DIV_LSB +: DIV_FIELD_W];
        if (m_dec == '0) m_dec = MUL_FIELD_W'(1);
        if (d_dec == '0) d_dec = DIV_FIELD_W'(1);
    end

    always_comb begin
        st_d        = st_q;
        st_d.done   = 1'b0;
        st_d.dstart = 1'b0;
        unique case (st_q.state)
            ST_IDLE: begin
                if (start_i && !st_q.done) begin
                    st_d.rate = rate_kbps_i;
                    st_d.refk = ref_khz_i;
                    if (ref_khz_i == '0) begin
                        st_d.err  = 1'b1;
                        st_d.done = 1'b1;
                        st_d.word = '0;
                        st_d.ach  = '0;
                        st_d.dec  = '0;
                        st_d.lp   = '0;
                    end else begin
                        st_d.err   = 1'b0;
                        st_d.div   = DIV_W'(1);
                        st_d.state = ST_SEARCH;
                    end
                end
            end
            ST_SEARCH: begin
                if (st_q.div < DIV_W'(MAX_DIV) &&
                    P'(st_q.refk) >= P'(MIN_POST_KHZ) * (P'(st_q.div) + P'(1))) begin
                    st_d.div = st_q.div + DIV_W'(1);
                end else begin
                    st_d.opa    = P'(st_q.rate) * P'(st_q.div) + P'(st_q.refk) - P'(1);
                    st_d.opb    = P'(st_q.refk);
                    st_d.dstart = 1'b1;
                    st_d.state  = ST_MUL;
                end
            end
            ST_MUL: begin
                if (dv_done) begin
                    st_d.mul_lo = dv_quot[WORD_W-1:0];
                    st_d.opa    = P'(st_q.refk) * dv_quot;
                    st_d.opb    = P'(st_q.div);
                    st_d.dstart = 1'b1;
                    st_d.state  = ST_ACH;
                end
            end
            ST_ACH: begin
                if (dv_done) begin
                    st_d.ach    = dv_quot;
                    st_d.word   = word_w;
                    st_d.opa    = P'(st_q.refk) * P'(m_dec);
                    st_d.opb    = P'(d_dec);
                    st_d.dstart = 1'b1;
                    st_d.state  = ST_DEC;
                end
            end
            ST_DEC: begin
                if (dv_done) begin
                    st_d.dec    = dv_quot;
                    st_d.opa    = dv_quot + P'(LP_STEP - 1);
                    st_d.opb    = P'(LP_STEP);
                    st_d.dstart = 1'b1;
                    st_d.state  = ST_LP;
                end
            end
            ST_LP: begin
                if (dv_done) begin
                    st_d.lp    = dv_quot;
                    st_d.done  = 1'b1;
                    st_d.state = ST_IDLE;
                end
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o    = (st_q.state != ST_IDLE);
    assign done_o    = st_q.done;
    assign err_o     = st_q.err;
    assign word_o    = st_q.word;
    assign ach_khz_o = st_q.ach;
    assign dec_khz_o = st_q.dec;
    assign lp_div_o  = st_q.lp;

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R1
    div_field_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o) |-> (word_o[DIV_LSB +: DIV_FIELD_W] != '0 &&
                                word_o[DIV_LSB +: DIV_FIELD_W] <= DIV_FIELD_W'(MAX_DIV)));

    // R7
    lp_covers_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o) |-> (lp_div_o * P'(LP_STEP) >= dec_khz_o));

    // R9
    err_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o) |-> (word_o == '0 && lp_div_o == '0 && !busy_o));
endmodule

// File: tb/test_pll_word_calc.sv
module test_pll_word_calc;
    typedef struct packed {
        logic [31:0] rate;
        logic [31:0] refk;
        logic [15:0] word;
        logic [63:0] ach;
        logic [63:0] dec;
        logic [63:0] lp;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TBL [NV] = '{
        '{32'd500000,  32'd27000,  16'hC55D, 64'd502200,  64'd502200,  64'd7},
        '{32'd300000,  32'd12000,  16'h8232, 64'd300000,  64'd300000,  64'd4},
        '{32'd100000,  32'd4000,   16'h0119, 64'd100000,  64'd100000,  64'd2},
        '{32'd1000000, 32'd200000, 16'hDF9B, 64'd1000000, 64'd1000000, 64'd13},
        '{32'd126000,  32'd6000,   16'h4115, 64'd126000,  64'd126000,  64'd2},
        '{32'd125000,  32'd1000,   16'h017D, 64'd125000,  64'd125000,  64'd2},
        '{32'd251000,  32'd1000,   16'h81FB, 64'd251000,  64'd251000,  64'd4},
        '{32'd250000,  32'd1000,   16'h41FA, 64'd250000,  64'd250000,  64'd4},
        '{32'd501000,  32'd3000,   16'hC1A7, 64'd501000,  64'd501000,  64'd7},
        '{32'd498000,  32'd3000,   16'h81A6, 64'd498000,  64'd498000,  64'd7},
        '{32'd100000,  32'd10000,  16'h0214, 64'd100000,  64'd100000,  64'd2},
        '{32'd100000,  32'd9999,   16'h010B, 64'd109989,  64'd109989,  64'd2},
        '{32'd100000,  32'd15001,  16'h0314, 64'd100006,  64'd100006,  64'd2},
        '{32'd1280000, 32'd5000,   16'hC100, 64'd1280000, 64'd5000,    64'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] rate = '0;
    logic [31:0] refk = '0;
    logic        busy, done, err;
    logic [15:0] word;
    logic [63:0] ach, dec, lp;

    int checks = 0;
    int errors = 0;
    int busy_seen;

    always #4 clk = ~clk;

    pll_word_calc i_pll_word_calc (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .rate_kbps_i (rate),
        .ref_khz_i   (refk),
        .busy_o      (busy),
        .done_o      (done),
        .err_o       (err),
        .word_o      (word),
        .ach_khz_o   (ach),
        .dec_khz_o   (dec),
        .lp_div_o    (lp)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run(input logic [31:0] r, input logic [31:0] f, input bit poke);
        int n;
        @(negedge clk);
        start = 1'b1;
        rate  = r;
        refk  = f;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        busy_seen = 0;
        while (!done && n < 3000) begin
            if (busy) busy_seen = 1;
            if (poke && n == 10) begin
                start = 1'b1;
                rate  = 32'd7;
                refk  = 32'd0;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        if (n >= 3000) begin
            checks++;
            errors++;
            $display("FAIL R8 watchdog actual=%0d expected=done", n);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 done", done, 0);
        chk("R10 busy", busy, 0);
        chk("R10 err", err, 0);
        chk("R10 word", word, 0);
        chk("R10 lp", lp, 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            run(TBL[i].rate, TBL[i].refk, 1'b0);
            chk("R1 divider field", word[12:8], TBL[i].word[12:8]);
            chk("R2 multiplier field", word[7:0], TBL[i].word[7:0]);
            chk("R4 band field", word[15:14], TBL[i].word[15:14]);
            chk("R5 word", word, TBL[i].word);
            chk("R3 achieved", ach, TBL[i].ach);
            chk("R6 decoded", dec, TBL[i].dec);
            chk("R7 lp divider", lp, TBL[i].lp);
            chk("R9 err low", err, 0);
        end

        // R9 zero reference
        run(32'd100000, 32'd0, 1'b0);
        chk("R9 err", err, 1);
        chk("R9 word", word, 0);
        chk("R9 achieved", ach, 0);
        chk("R9 decoded", dec, 0);
        chk("R9 lp", lp, 0);
        @(negedge clk);
        chk("R8 done one cycle", done, 0);

        // R8 start during a run is ignored
        run(32'd500000, 32'd27000, 1'b1);
        chk("R8 busy seen", busy_seen, 1);
        chk("R8 word", word, 16'hC55D);
        chk("R8 lp", lp, 7);
        chk("R8 err", err, 0);
        @(negedge clk);
        chk("R8 done drops", done, 0);
        chk("R8 idle after", busy, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule